// File: doc/BRIEF.md
# Cascadable Registered ALU Slice

This block is one narrow slice of a wider data path. It holds a small two-read-port register file, a working register (Q), a selector that picks an operand pair, an eight-function ALU and two shifters, one on the register-file writeback path and one on the Q path. Slices sit side by side to build a wider word. Carry look-ahead between slices uses the generate and propagate outputs, and the shifter end bits are passed between neighbouring slices.

Each cycle a 9-bit control word, split into three 3-bit fields, steers the slice. The source field picks the (R, S) operand pair. The function field picks the operation. The destination field picks the writeback target and the shift direction at the same time. The ALU result always appears on the data output, whatever the destination does. All storage is edge-triggered on one clock and is cleared by an active-low asynchronous reset.

Top module: `alu_slice`

## Requirements
- R1: `src_sel` selects the (R,S) pair: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). A and B are the register-file words at `addr_a` and `addr_b`, and D is `din`.
- R2: `fn_sel` selects the operation: 0=R+S+cin, 1=S+~R+cin (S minus R, two's complement when cin=1), 2=R+~S+cin (R minus S), 3=R|S, 4=R&S, 5=~R&S, 6=R^S, 7=~(R^S).
- R3: `ovf` is the carry into the top bit XOR the carry out of it. `zero` is set when `y` is all zero and `sign` equals `y[3]`. For logic functions (codes 3 to 7), `cout`, `ovf`, `gen` and `prop` are 0.
- R4: For arithmetic functions, `gen` means the slice produces a carry with cin=0 and `prop` means every bit passes a carry, so `cout` = `gen | (prop & cin)`.
- R5: `y` is always the ALU result and is never a shifter output, for every destination code.
- R6: A write goes only to the word at `addr_b` and takes effect after the clock edge. A read of that word in the same cycle returns the old value. Other words are unchanged.
- R7: `dst_sel` codes: 0 = load Q from the ALU; 1 = no load; 2 = write the ALU result to B; 3 = write the ALU result to both B and Q; 4 = shift B and Q down; 5 = shift B down; 6 = shift B and Q up; 7 = shift B up. Q keeps its value under codes 1, 2, 5 and 7.
- R8: Down shift (codes 4, 5): B is written with {`rf_hi_in`, F[3:1]} and `rf_lo_out` = F[0]. Under code 4 only, Q becomes {`q_hi_in`, Q[3:1]} and `q_lo_out` = Q[0]. `shift_dn` = 1.
- R9: Up shift (codes 6, 7): B is written with {F[2:0], `rf_lo_in`} and `rf_hi_out` = F[3]. Under code 6 only, Q becomes {Q[2:0], `q_lo_in`} and `q_hi_out` = Q[3]. `shift_up` = 1.
- R10: Any cascade output that the current code does not use drives 0. `shift_dn` and `shift_up` are never both high.
- R11: Reset clears every register-file word and Q to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 3 | Operand-pair code |
| fn_sel | input | 3 | ALU function code |
| dst_sel | input | 3 | Writeback and shift code |
| addr_a | input | 4 | Register-file read address A |
| addr_b | input | 4 | Register-file read/write address B |
| din | input | 4 | External data operand |
| cin | input | 1 | Carry input |
| rf_lo_in | input | 1 | Register-file bit-0 fill on up shift |
| rf_hi_in | input | 1 | Register-file bit-3 fill on down shift |
| q_lo_in | input | 1 | Q bit-0 fill on up shift |
| q_hi_in | input | 1 | Q bit-3 fill on down shift |
| y | output | 4 | ALU result |
| cout | output | 1 | Carry out |
| gen | output | 1 | Slice carry generate |
| prop | output | 1 | Slice carry propagate |
| ovf | output | 1 | Signed overflow |
| sign | output | 1 | Result MSB |
| zero | output | 1 | Result is all zero |
| rf_lo_out | output | 1 | Register-file bit 0 leaving on down shift |
| rf_hi_out | output | 1 | Register-file bit 3 leaving on up shift |
| q_lo_out | output | 1 | Q bit 0 leaving on down shift |
| q_hi_out | output | 1 | Q bit 3 leaving on up shift |
| shift_dn | output | 1 | Down shift active this cycle |
| shift_up | output | 1 | Up shift active this cycle |

## Verification
The register file and Q can only be seen through the ALU. A wrong stored word therefore shows on `y` in the first cycle after the faulty edge that selects it as an operand, for example (0,A) with OR. A Q register that loads, holds or shifts wrongly shows on `y` in the next cycle under source code 2. A fault in the adder's carry chain shows in the same cycle as a mismatch between `cout` and `gen`/`prop`, or as a wrong `ovf` on operands that carry into the top bit. A cascade fault shows in the same cycle on the end-bit outputs, and in the stored word one cycle later.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    SRC_AQ = 3'd0,
    SRC_AB = 3'd1,
    SRC_ZQ = 3'd2,
    SRC_ZB = 3'd3,
    SRC_ZA = 3'd4,
    SRC_DA = 3'd5,
    SRC_DQ = 3'd6,
    SRC_DZ = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SUBR  = 3'd1,
    FN_RSUB  = 3'd2,
    FN_OR    = 3'd3,
    FN_AND   = 3'd4,
    FN_NOTRS = 3'd5,
    FN_XOR   = 3'd6,
    FN_XNOR  = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    DST_LDQ  = 3'd0,
    DST_NOP  = 3'd1,
    DST_WRB  = 3'd2,
    DST_WRBQ = 3'd3,
    DST_SDQ  = 3'd4,
    DST_SD   = 3'd5,
    DST_SUQ  = 3'd6,
    DST_SU   = 3'd7
  } dst_e;

  typedef struct packed {
    logic rf_we;
    logic q_load;
    logic q_shift;
    logic shift_dn;
    logic shift_up;
  } dst_ctl_t;

  function automatic dst_ctl_t decode_dst(input dst_e d);
    dst_ctl_t c;
    c = '0;
    case (d)
      DST_LDQ:  c.q_load = 1'b1;
      DST_NOP:  c = '0;
      DST_WRB:  c.rf_we = 1'b1;
      DST_WRBQ: begin c.rf_we = 1'b1; c.q_load = 1'b1; end
      DST_SDQ:  begin c.rf_we = 1'b1; c.shift_dn = 1'b1; c.q_shift = 1'b1; end
      DST_SD:   begin c.rf_we = 1'b1; c.shift_dn = 1'b1; end
      DST_SUQ:  begin c.rf_we = 1'b1; c.shift_up = 1'b1; c.q_shift = 1'b1; end
      DST_SU:   begin c.rf_we = 1'b1; c.shift_up = 1'b1; end
      default:  c = '0;
    endcase
    return c;
  endfunction

  function automatic logic fn_is_arith(input fn_e f);
    return (f == FN_ADD) || (f == FN_SUBR) || (f == FN_RSUB);
  endfunction

endpackage

// File: rtl/alu_slice_regfile.sv
module alu_slice_regfile #(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr_b] <= wdata;
    end
  end

  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];
endmodule

// File: rtl/alu_slice_opsel.sv
module alu_slice_opsel
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  src_e         src,
  input  logic [W-1:0] rd_a,
  input  logic [W-1:0] rd_b,
  input  logic [W-1:0] q,
  input  logic [W-1:0] din,
  output logic [W-1:0] r,
  output logic [W-1:0] s
);
  always_comb begin
    case (src)
      SRC_AQ:  begin r = rd_a; s = q;    end
      SRC_AB:  begin r = rd_a; s = rd_b; end
      SRC_ZQ:  begin r = '0;   s = q;    end
      SRC_ZB:  begin r = '0;   s = rd_b; end
      SRC_ZA:  begin r = '0;   s = rd_a; end
      SRC_DA:  begin r = din;  s = rd_a; end
      SRC_DQ:  begin r = din;  s = q;    end
      SRC_DZ:  begin r = din;  s = '0;   end
      default: begin r = '0;   s = '0;   end
    endcase
  end
endmodule

// File: rtl/alu_slice_alu.sv
module alu_slice_alu
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  fn_e          fn,
  input  logic [W-1:0] r,
  input  logic [W-1:0] s,
  input  logic         cin,
  output logic [W-1:0] f,
  output logic         cout,
  output logic         gen,
  output logic         prop,
  output logic         ovf,
  output logic         sign,
  output logic         zero
);
  // Ripple sum; returns {carry into MSB, carry out, sum}.
  function automatic logic [W+1:0] ripple(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic ci);
    logic         c;
    logic         cm;
    logic [W-1:0] sm;
    c  = ci;
    cm = ci;
    sm = '0;
    for (int i = 0; i < W; i++) begin
      if (i == W - 1) cm = c;
      sm[i] = a[i] ^ b[i] ^ c;
      c     = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
    end
    return {cm, c, sm};
  endfunction

  // Group look-ahead terms; returns {generate, propagate}.
  function automatic logic [1:0] lookahead(input logic [W-1:0] a, input logic [W-1:0] b);
    logic gg;
    logic pp;
    gg = 1'b0;
    pp = 1'b1;
    for (int i = 0; i < W; i++) begin
      gg = (a[i] & b[i]) | ((a[i] | b[i]) & gg);
      pp = pp & (a[i] | b[i]);
    end
    return {gg, pp};
  endfunction

  logic [W-1:0] ax;
  logic [W-1:0] ay;
  logic [W+1:0] rip;
  logic [1:0]   gp;
  logic         arith;

  always_comb begin
    ax    = (fn == FN_SUBR) ? ~r : r;
    ay    = (fn == FN_RSUB) ? ~s : s;
    rip   = ripple(ax, ay, cin);
    gp    = lookahead(ax, ay);
    arith = fn_is_arith(fn);
    case (fn)
      FN_OR:    f = r | s;
      FN_AND:   f = r & s;
      FN_NOTRS: f = ~r & s;
      FN_XOR:   f = r ^ s;
      FN_XNOR:  f = ~(r ^ s);
      default:  f = rip[W-1:0];
    endcase
    cout = arith & rip[W];
    ovf  = arith & (rip[W+1] ^ rip[W]);
    gen  = arith & gp[1];
    prop = arith & gp[0];
    sign = f[W-1];
    zero = (f == '0);
  end
endmodule

// File: rtl/alu_slice_shift.sv
module alu_slice_shift #(
  parameter int W = 4
) (
  input  logic [W-1:0] data,
  input  logic         dn,
  input  logic         up,
  input  logic         fill_lo,
  input  logic         fill_hi,
  output logic [W-1:0] shifted,
  output logic         end_lo,
  output logic         end_hi
);
  always_comb begin
    if (dn)      shifted = {fill_hi, data[W-1:1]};
    else if (up) shifted = {data[W-2:0], fill_lo};
    else         shifted = data;
    end_lo = dn & data[0];
    end_hi = up & data[W-1];
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    src_sel,
  input  logic [2:0]    fn_sel,
  input  logic [2:0]    dst_sel,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [W-1:0]  din,
  input  logic          cin,
  input  logic          rf_lo_in,
  input  logic          rf_hi_in,
  input  logic          q_lo_in,
  input  logic          q_hi_in,
  output logic [W-1:0]  y,
  output logic          cout,
  output logic          gen,
  output logic          prop,
  output logic          ovf,
  output logic          sign,
  output logic          zero,
  output logic          rf_lo_out,
  output logic          rf_hi_out,
  output logic          q_lo_out,
  output logic          q_hi_out,
  output logic          shift_dn,
  output logic          shift_up
);
  // Named internal events, visible to the bound checker.
  dst_ctl_t     dctl;
  logic [W-1:0] rd_a;
  logic [W-1:0] rd_b;
  logic [W-1:0] r_op;
  logic [W-1:0] s_op;
  logic [W-1:0] f;
  logic [W-1:0] q_q;
  logic [W-1:0] q_sh;
  logic [W-1:0] q_next;
  logic         q_we;
  logic         rf_we;
  logic [W-1:0] rf_wdata;
  logic         q_dn;
  logic         q_up;

  assign dctl  = decode_dst(dst_e'(dst_sel));
  assign rf_we = dctl.rf_we;
  assign q_dn  = dctl.shift_dn & dctl.q_shift;
  assign q_up  = dctl.shift_up & dctl.q_shift;
  assign q_we  = dctl.q_load | dctl.q_shift;

  alu_slice_regfile #(.W(W), .AW(AW)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_a (addr_a),
    .addr_b (addr_b),
    .we     (rf_we),
    .wdata  (rf_wdata),
    .rd_a   (rd_a),
    .rd_b   (rd_b)
  );

  alu_slice_opsel #(.W(W)) u_sel (
    .src  (src_e'(src_sel)),
    .rd_a (rd_a),
    .rd_b (rd_b),
    .q    (q_q),
    .din  (din),
    .r    (r_op),
    .s    (s_op)
  );

  alu_slice_alu #(.W(W)) u_alu (
    .fn   (fn_e'(fn_sel)),
    .r    (r_op),
    .s    (s_op),
    .cin  (cin),
    .f    (f),
    .cout (cout),
    .gen  (gen),
    .prop (prop),
    .ovf  (ovf),
    .sign (sign),
    .zero (zero)
  );

  alu_slice_shift #(.W(W)) u_rf_shift (
    .data    (f),
    .dn      (dctl.shift_dn),
    .up      (dctl.shift_up),
    .fill_lo (rf_lo_in),
    .fill_hi (rf_hi_in),
    .shifted (rf_wdata),
    .end_lo  (rf_lo_out),
    .end_hi  (rf_hi_out)
  );

  alu_slice_shift #(.W(W)) u_q_shift (
    .data    (q_q),
    .dn      (q_dn),
    .up      (q_up),
    .fill_lo (q_lo_in),
    .fill_hi (q_hi_in),
    .shifted (q_sh),
    .end_lo  (q_lo_out),
    .end_hi  (q_hi_out)
  );

  assign q_next = dctl.q_shift ? q_sh : f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_we) q_q <= q_next;
  end

  assign y        = f;
  assign shift_dn = dctl.shift_dn;
  assign shift_up = dctl.shift_up;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    fn_sel,
  input logic [2:0]    dst_sel,
  input logic [AW-1:0] addr_b,
  input logic          cin,
  input logic          cout,
  input logic          gen,
  input logic          prop,
  input logic          ovf,
  input logic          q_lo_in,
  input logic          q_hi_in,
  input logic          rf_lo_out,
  input logic          rf_hi_out,
  input logic          q_lo_out,
  input logic          q_hi_out,
  input logic          shift_dn,
  input logic          shift_up,
  input logic          rf_we,
  input logic [W-1:0]  rf_wdata,
  input logic [W-1:0]  rd_b,
  input logic [W-1:0]  q_q,
  input logic          q_we
);
  logic past_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // R6: a write to B is visible at the B port after the edge
  assert_rf_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(rf_we) && addr_b == $past(addr_b)) |-> rd_b == $past(rf_wdata));

  // R7: Q changes only when its destination code enables it
  assert_q_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(q_we)) |-> q_q == $past(q_q));

  // R8: Q shifts down with the bit-3 fill
  assert_q_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(dst_sel) == 3'd4) |-> q_q == {$past(q_hi_in), $past(q_q[W-1:1])});

  // R9: Q shifts up with the bit-0 fill
  assert_q_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(dst_sel) == 3'd6) |-> q_q == {$past(q_q[W-2:0]), $past(q_lo_in)});

  // R3: logic functions leave all carry-related flags low
  assert_logic_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel >= 3'd3) |-> (!cout && !ovf && !gen && !prop));

  // R4: ripple carry-out agrees with the look-ahead terms
  assert_carry_lookahead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cout == (gen | (prop & cin)));

  // R10: cascade outputs idle when no shift
  assert_cascade_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_dn && !shift_up) |-> !(rf_lo_out | rf_hi_out | q_lo_out | q_hi_out));

  // R10: never both directions
  assert_shift_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_dn, shift_up}));
endmodule

bind alu_slice alu_slice_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fn_sel    (fn_sel),
  .dst_sel   (dst_sel),
  .addr_b    (addr_b),
  .cin       (cin),
  .cout      (cout),
  .gen       (gen),
  .prop      (prop),
  .ovf       (ovf),
  .q_lo_in   (q_lo_in),
  .q_hi_in   (q_hi_in),
  .rf_lo_out (rf_lo_out),
  .rf_hi_out (rf_hi_out),
  .q_lo_out  (q_lo_out),
  .q_hi_out  (q_hi_out),
  .shift_dn  (shift_dn),
  .shift_up  (shift_up),
  .rf_we     (rf_we),
  .rf_wdata  (rf_wdata),
  .rd_b      (rd_b),
  .q_q       (q_q),
  .q_we      (q_we)
);

// File: tb/tb_alu_slice.sv
module tb_alu_slice;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] src_sel, fn_sel, dst_sel;
  logic [3:0] addr_a, addr_b, din;
  logic       cin, rf_lo_in, rf_hi_in, q_lo_in, q_hi_in;
  logic [3:0] y;
  logic       cout, gen, prop, ovf, sign, zero;
  logic       rf_lo_out, rf_hi_out, q_lo_out, q_hi_out, shift_dn, shift_up;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  alu_slice dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .fn_sel(fn_sel), .dst_sel(dst_sel),
    .addr_a(addr_a), .addr_b(addr_b), .din(din), .cin(cin),
    .rf_lo_in(rf_lo_in), .rf_hi_in(rf_hi_in), .q_lo_in(q_lo_in), .q_hi_in(q_hi_in),
    .y(y), .cout(cout), .gen(gen), .prop(prop), .ovf(ovf), .sign(sign), .zero(zero),
    .rf_lo_out(rf_lo_out), .rf_hi_out(rf_hi_out), .q_lo_out(q_lo_out), .q_hi_out(q_hi_out),
    .shift_dn(shift_dn), .shift_up(shift_up)
  );

  // {src, fn, cin, y, cout, ovf, zero} with A=6, B=3, Q=A, D=9
  localparam logic [13:0] VEC [10] = '{
    {3'd1, 3'd0, 1'b0, 4'h9, 1'b0, 1'b1, 1'b0},
    {3'd0, 3'd1, 1'b1, 4'h4, 1'b1, 1'b1, 1'b0},
    {3'd3, 3'd2, 1'b1, 4'hD, 1'b0, 1'b0, 1'b0},
    {3'd5, 3'd3, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0},
    {3'd6, 3'd4, 1'b0, 4'h8, 1'b0, 1'b0, 1'b0},
    {3'd4, 3'd5, 1'b0, 4'h6, 1'b0, 1'b0, 1'b0},
    {3'd2, 3'd6, 1'b0, 4'hA, 1'b0, 1'b0, 1'b0},
    {3'd7, 3'd7, 1'b0, 4'h6, 1'b0, 1'b0, 1'b0},
    {3'd1, 3'd0, 1'b1, 4'hA, 1'b0, 1'b1, 1'b0},
    {3'd0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1}
  };

  // Integer reference: returns {y, cout, ovf, gen, prop}
  function automatic logic [7:0] ref_alu(int src, int fn, int ci, int a, int b, int q, int d);
    int r, s, x, t, sum, sx, st, ssum, yv, co, ov, g, p;
    case (src)
      0: begin r = a; s = q; end
      1: begin r = a; s = b; end
      2: begin r = 0; s = q; end
      3: begin r = 0; s = b; end
      4: begin r = 0; s = a; end
      5: begin r = d; s = a; end
      6: begin r = d; s = q; end
      default: begin r = d; s = 0; end
    endcase
    co = 0; ov = 0; g = 0; p = 0;
    if (fn <= 2) begin
      x = (fn == 1) ? 15 - r : r;
      t = (fn == 2) ? 15 - s : s;
      sum  = x + t + ci;
      yv   = sum % 16;
      co   = (sum >= 16) ? 1 : 0;
      sx   = (x > 7) ? x - 16 : x;
      st   = (t > 7) ? t - 16 : t;
      ssum = sx + st + ci;
      ov   = (ssum > 7 || ssum < -8) ? 1 : 0;
      g    = (x + t >= 16) ? 1 : 0;
      p    = ((x | t) == 15) ? 1 : 0;
    end else begin
      case (fn)
        3: yv = r | s;
        4: yv = r & s;
        5: yv = (15 - r) & s;
        6: yv = r ^ s;
        default: yv = 15 - (r ^ s);
      endcase
    end
    return {yv[3:0], co[0], ov[0], g[0], p[0]};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int src, input int fn, input int dst, input int a, input int b,
                       input int d, input int ci);
    @(negedge clk);
    src_sel = src[2:0]; fn_sel = fn[2:0]; dst_sel = dst[2:0];
    addr_a = a[3:0]; addr_b = b[3:0]; din = d[3:0]; cin = ci[0];
    #1;
  endtask

  task automatic write_rf(input int b, input int v);
    drive(7, 3, 2, 0, b, v, 0);
  endtask

  task automatic load_q(input int v);
    drive(7, 3, 0, 0, 0, v, 0);
  endtask

  task automatic read_rf(input int a, output int v);
    drive(4, 3, 1, a, 0, 0, 0);
    v = int'(y);
  endtask

  task automatic read_q(output int v);
    drive(2, 3, 1, 0, 0, 0, 0);
    v = int'(y);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    logic [7:0] e;
    rst_n = 1'b0;
    src_sel = 3'd0; fn_sel = 3'd3; dst_sel = 3'd1;
    addr_a = 4'd0; addr_b = 4'd0; din = 4'd0; cin = 1'b0;
    rf_lo_in = 1'b0; rf_hi_in = 1'b0; q_lo_in = 1'b0; q_hi_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    read_rf(0, v);  chk("R11", "rf[0] after reset", v, 0);
    read_rf(15, v); chk("R11", "rf[15] after reset", v, 0);
    read_q(v);      chk("R11", "Q after reset", v, 0);
    chk("R10", "cascade outs idle", {rf_lo_out, rf_hi_out, q_lo_out, q_hi_out, shift_dn, shift_up}, 0);

    // preload operands
    write_rf(2, 6);
    write_rf(5, 3);
    load_q(4'hA);

    // vector table (R1, R2, R3)
    for (int i = 0; i < 10; i++) begin
      drive(VEC[i][13:11], VEC[i][10:8], 1, 2, 5, 9, VEC[i][7]);
      chk("R1/R2", $sformatf("vec %0d y", i), y, VEC[i][6:3]);
      chk("R3", $sformatf("vec %0d cout", i), cout, VEC[i][2]);
      chk("R3", $sformatf("vec %0d ovf", i), ovf, VEC[i][1]);
      chk("R3", $sformatf("vec %0d zero", i), zero, VEC[i][0]);
      chk("R3", $sformatf("vec %0d sign", i), sign, VEC[i][6]);
    end

    // every source/function pair, both carry-in values (R1, R2, R3, R4)
    for (int sidx = 0; sidx < 8; sidx++) begin
      for (int fidx = 0; fidx < 8; fidx++) begin
        for (int c = 0; c < 2; c++) begin
          drive(sidx, fidx, 1, 2, 5, 9, c);
          e = ref_alu(sidx, fidx, c, 6, 3, 10, 9);
          chk("R2", $sformatf("src %0d fn %0d cin %0d y", sidx, fidx, c), y, e[7:4]);
          chk("R3", $sformatf("src %0d fn %0d cin %0d cout/ovf", sidx, fidx, c),
              {cout, ovf}, e[3:2]);
          chk("R4", $sformatf("src %0d fn %0d cin %0d gen/prop", sidx, fidx, c),
              {gen, prop}, e[1:0]);
        end
      end
    end

    // R6: same-cycle read returns old value; only B is written
    drive(5, 6, 2, 5, 5, 4'hC, 0);
    chk("R6", "y reads old word during write", y, 4'hF);
    read_rf(5, v); chk("R6", "rf[5] after write", v, 4'hF);
    read_rf(2, v); chk("R6", "rf[2] untouched", v, 6);

    // R7: Q held under codes 1, 2, 5, 7
    drive(7, 3, 1, 0, 9, 1, 0);
    drive(7, 3, 2, 0, 9, 1, 0);
    drive(7, 3, 5, 0, 9, 1, 0);
    drive(7, 3, 7, 0, 9, 1, 0);
    read_q(v); chk("R7", "Q held", v, 4'hA);
    drive(7, 3, 3, 0, 9, 7, 0);
    read_q(v);     chk("R7", "Q after write-both", v, 7);
    read_rf(9, v); chk("R7", "rf[9] after write-both", v, 7);

    // R8 down shift with Q
    load_q(4'hA);
    rf_hi_in = 1'b1; q_hi_in = 1'b0; rf_lo_in = 1'b1; q_lo_in = 1'b1;
    drive(7, 3, 4, 0, 9, 4'b1011, 0);
    chk("R5", "y during down shift", y, 4'hB);
    chk("R8", "rf_lo_out", rf_lo_out, 1);
    chk("R8", "q_lo_out", q_lo_out, 0);
    chk("R8", "shift_dn/shift_up", {shift_dn, shift_up}, 2'b10);
    chk("R10", "high ends idle on down", {rf_hi_out, q_hi_out}, 0);
    read_rf(9, v); chk("R8", "rf[9] down shifted", v, 4'hD);
    read_q(v);     chk("R8", "Q down shifted", v, 5);

    // R8 down shift without Q, Q[0]=1
    rf_hi_in = 1'b0;
    drive(7, 3, 5, 0, 9, 4'b0100, 0);
    chk("R10", "q_lo_out idle when Q not shifting", q_lo_out, 0);
    chk("R8", "rf_lo_out code 5", rf_lo_out, 0);
    read_rf(9, v); chk("R8", "rf[9] code 5", v, 2);
    read_q(v);     chk("R8", "Q unchanged code 5", v, 5);

    // R9 up shift with Q
    rf_lo_in = 1'b1; q_lo_in = 1'b1; rf_hi_in = 1'b1; q_hi_in = 1'b1;
    drive(7, 3, 6, 0, 9, 4'b1110, 0);
    chk("R5", "y during up shift", y, 4'hE);
    chk("R9", "rf_hi_out", rf_hi_out, 1);
    chk("R9", "q_hi_out", q_hi_out, 0);
    chk("R9", "shift_dn/shift_up", {shift_dn, shift_up}, 2'b01);
    chk("R10", "low ends idle on up", {rf_lo_out, q_lo_out}, 0);
    read_rf(9, v); chk("R9", "rf[9] up shifted", v, 4'hD);
    read_q(v);     chk("R9", "Q up shifted", v, 4'hB);

    // R9 up shift without Q, Q[3]=1
    rf_lo_in = 1'b0;
    drive(7, 3, 7, 0, 9, 4'b0011, 0);
    chk("R10", "q_hi_out idle when Q not shifting", q_hi_out, 0);
    chk("R9", "rf_hi_out code 7", rf_hi_out, 0);
    read_rf(9, v); chk("R9", "rf[9] code 7", v, 6);
    read_q(v);     chk("R9", "Q unchanged code 7", v, 4'hB);

    finish_run();
  end
endmodule